// File: doc/BRIEF.md
# Audio Sample FIFO with Status Interrupts

This block is one direction of an audio sample queue: a producer pushes 16-bit samples, a consumer pops them, and the block reports how full the queue is. A live fill count comes out together with four level flags: empty, full, and two threshold flags. The threshold flags are placed by a 6-bit watermark input. Transmit channels typically run a small watermark such as 4, and receive channels a large one such as 32. Two sticky error flags record a pop from an empty queue (starvation) and a push into a full queue (overflow).

Six interrupt sources can each be masked. A global enable gates the masked sources into a single pending line, and a clear strobe drops that line. The consumer side returns each sample with a valid bit, so a pop that found nothing can be told apart from a sample of zero. When DMA service is enabled, a request line asks for the queue to be drained whenever it holds data. The queue accepts and delivers samples only while its enable is high. Dropping the enable empties it.

Top module: `smpl_fifo_irq`

## Requirements
- R1: Samples come out in the order they went in. The cycle after a pop from a non-empty queue, `rd_data[16]` is 1 and `rd_data[15:0]` holds the oldest sample. In every other cycle, including the cycle after a pop that found the queue empty, `rd_data` is all zero.
- R2: `count` gives the number of stored samples, from 0 to DEPTH (32). `empty` is high exactly when the count is 0, and `full` is high exactly when the count is DEPTH. A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged.
- R3: `almost_full` is high exactly when count + `dipstick` >= DEPTH.
- R4: `almost_empty` is high exactly when count <= `dipstick`.
- R5: A push while `full` is discarded, even if a pop happens in the same cycle. `ovfl_err` goes high at that edge and stays high until a clear.
- R6: A pop while `empty` returns no data, as R1 describes. `starve_err` goes high at that edge and stays high until a clear.
- R7: While `fifo_en` is low, pushes and pops are ignored and raise no error. The count and both pointers return to zero at the next edge.
- R8: `dma_req` is high exactly when `dma_en` and `fifo_en` are high and the queue is not empty.
- R9: The bits of `irq_mask` map to sources as follows: bit 0 empty, bit 1 almost-empty, bit 2 full, bit 3 almost-full, bit 4 starvation event, bit 5 overflow event. If `irq_global_en` is high and any masked-in source is active in a cycle, `irq_pending` is 1 after that edge. The level sources are the registered flags. The two error sources are the offending push or pop itself.
- R10: `irq_clear` drops `irq_pending`, `ovfl_err` and `starve_err` at the next edge. A source that sets one of them in that same cycle wins, so the bit is 1 after the edge.
- R11: While `irq_global_en` is low, `irq_pending` cannot rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queue enable; low flushes |
| dma_en | input | 1 | Enables the DMA request |
| dipstick | input | 6 | Watermark for the threshold flags |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 16 | Sample to push |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 17 | Bit 16 valid, bits 15:0 sample, registered |
| count | output | 6 | Fill count |
| empty | output | 1 | Count is zero |
| almost_empty | output | 1 | Count at or below watermark |
| full | output | 1 | Count is DEPTH |
| almost_full | output | 1 | Count within watermark of DEPTH |
| starve_err | output | 1 | Sticky pop-on-empty error |
| ovfl_err | output | 1 | Sticky push-on-full error |
| dma_req | output | 1 | Drain request |
| irq_mask | input | 6 | Per-source interrupt enables |
| irq_global_en | input | 1 | Global interrupt gate |
| irq_clear | input | 1 | Clears pending and error flags |
| irq_pending | output | 1 | Combined interrupt line |

## Verification
The two functions that can meet in one cycle are the clear strobe and a new interrupt event. The bench provokes this in two ways. It pulses `irq_clear` in the same cycle as a pop on an empty queue, and it pulses it while the masked-in empty flag is still active. In both cases it requires the error and pending bits to read 1 after the edge. A second collision is a push and a pop together: the bench issues one on a partly filled queue and one on a full queue. It judges both by the count, by the order of the data, and by the overflow flag.

// File: rtl/smpl_fifo_pkg.sv
package smpl_fifo_pkg;

   localparam int N_SRC = 6;

   // interrupt source positions in the mask and source vectors
   typedef enum int {
      SRC_EMPTY   = 0,
      SRC_AEMPTY  = 1,
      SRC_FULL    = 2,
      SRC_AFULL   = 3,
      SRC_STARVE  = 4,
      SRC_OVFL    = 5
   } src_idx_e;

   typedef struct packed {
      logic afull;
      logic full;
      logic aempty;
      logic empty;
   } level_flags_t;

endpackage

// File: rtl/smpl_fifo_store.sv
module smpl_fifo_store #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W:0]   pop_word,
   output logic [CNT_W-1:0]  fill
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (push) wptr <= wptr + PTR_W'(1);
         if (pop)  rptr <= rptr + PTR_W'(1);
         fill <= fill + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pop_word <= '0;
      else if (pop) pop_word <= {1'b1, mem[rptr]};
      else          pop_word <= '0;
   end

endmodule

// File: rtl/smpl_fifo_level.sv
module smpl_fifo_level
   import smpl_fifo_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DIP_W = 6,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int SUM_W = ((CNT_W > DIP_W) ? CNT_W : DIP_W) + 1
) (
   input  logic [CNT_W-1:0] fill,
   input  logic [DIP_W-1:0] dip,
   output level_flags_t     flags
);

   logic [SUM_W-1:0] fill_x, dip_x, sum_x;

   always_comb begin
      fill_x       = SUM_W'(fill);
      dip_x        = SUM_W'(dip);
      sum_x        = fill_x + dip_x;
      flags.empty  = (fill == '0);
      flags.full   = (fill_x == SUM_W'(DEPTH));
      flags.aempty = (fill_x <= dip_x);
      flags.afull  = (sum_x >= SUM_W'(DEPTH));
   end

endmodule

// File: rtl/smpl_fifo_irq_ctl.sv
module smpl_fifo_irq_ctl
   import smpl_fifo_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  level_flags_t     flags,
   input  logic             starve_evt,
   input  logic             ovfl_evt,
   input  logic [N_SRC-1:0] mask,
   input  logic             global_en,
   input  logic             clear,
   output logic             starve_q,
   output logic             ovfl_q,
   output logic             pending_q
);

   logic [N_SRC-1:0] src, hit;

   always_comb begin
      src              = '0;
      src[SRC_EMPTY]   = flags.empty;
      src[SRC_AEMPTY]  = flags.aempty;
      src[SRC_FULL]    = flags.full;
      src[SRC_AFULL]   = flags.afull;
      src[SRC_STARVE]  = starve_evt;
      src[SRC_OVFL]    = ovfl_evt;
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_gate
      assign hit[g] = src[g] & mask[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         starve_q  <= 1'b0;
         ovfl_q    <= 1'b0;
         pending_q <= 1'b0;
      end else begin
         starve_q  <= (starve_q & ~clear) | starve_evt;
         ovfl_q    <= (ovfl_q & ~clear) | ovfl_evt;
         pending_q <= (pending_q & ~clear) | (global_en & (|hit));
      end
   end

endmodule

// File: rtl/smpl_fifo_irq.sv
module smpl_fifo_irq
   import smpl_fifo_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 16,
   parameter int DIP_W  = 6,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              dma_en,
   input  logic [DIP_W-1:0]  dipstick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W:0]   rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              empty,
   output logic              almost_empty,
   output logic              full,
   output logic              almost_full,
   output logic              starve_err,
   output logic              ovfl_err,
   output logic              dma_req,
   input  logic [N_SRC-1:0]  irq_mask,
   input  logic              irq_global_en,
   input  logic              irq_clear,
   output logic              irq_pending
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("smpl_fifo_irq: DEPTH must be a power of two of at least 4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("smpl_fifo_irq: DATA_W must be positive");
   end
   if (DIP_W < 1) begin : g_bad_dip
      $error("smpl_fifo_irq: DIP_W must be positive");
   end

   level_flags_t flags;
   logic         push_ok, pop_ok, starve_evt, ovfl_evt;

   assign push_ok    = fifo_en & wr_en & ~flags.full;
   assign pop_ok     = fifo_en & rd_en & ~flags.empty;
   assign ovfl_evt   = fifo_en & wr_en & flags.full;
   assign starve_evt = fifo_en & rd_en & flags.empty;

   smpl_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (~fifo_en),
      .push      (push_ok),
      .push_data (wr_data),
      .pop       (pop_ok),
      .pop_word  (rd_data),
      .fill      (count)
   );

   smpl_fifo_level #(.DEPTH(DEPTH), .DIP_W(DIP_W)) u_level (
      .fill  (count),
      .dip   (dipstick),
      .flags (flags)
   );

   smpl_fifo_irq_ctl u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flags      (flags),
      .starve_evt (starve_evt),
      .ovfl_evt   (ovfl_evt),
      .mask       (irq_mask),
      .global_en  (irq_global_en),
      .clear      (irq_clear),
      .starve_q   (starve_err),
      .ovfl_q     (ovfl_err),
      .pending_q  (irq_pending)
   );

   assign empty        = flags.empty;
   assign almost_empty = flags.aempty;
   assign full         = flags.full;
   assign almost_full  = flags.afull;
   assign dma_req      = dma_en & fifo_en & ~flags.empty;

endmodule

// File: rtl/smpl_fifo_irq_chk.sv
module smpl_fifo_irq_chk #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_en,
   input logic              dma_en,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W:0]   rd_data,
   input logic [CNT_W-1:0]  count,
   input logic              empty,
   input logic              full,
   input logic              starve_err,
   input logic              ovfl_err,
   input logic              dma_req,
   input logic              irq_global_en,
   input logic              irq_clear,
   input logic              irq_pending
);

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_valid_needs_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W] |-> $past(fifo_en && rd_en && !empty));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && wr_en && full && !rd_en) |=> (count == $past(count)) && ovfl_err);

   assert_ovfl_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovfl_err && !irq_clear) |=> ovfl_err);

   assert_starve_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && rd_en && empty) |=> (starve_err && !rd_data[DATA_W]));

   assert_starve_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (starve_err && !irq_clear) |=> starve_err);

   assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (count == '0));

   assert_dma_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (dma_en && count != '0));

   assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clear && !irq_global_en) |=> !irq_pending);

   assert_gate_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_global_en && !irq_pending) |=> !irq_pending);

endmodule

bind smpl_fifo_irq smpl_fifo_irq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fifo_en       (fifo_en),
   .dma_en        (dma_en),
   .wr_en         (wr_en),
   .rd_en         (rd_en),
   .rd_data       (rd_data),
   .count         (count),
   .empty         (empty),
   .full          (full),
   .starve_err    (starve_err),
   .ovfl_err      (ovfl_err),
   .dma_req       (dma_req),
   .irq_global_en (irq_global_en),
   .irq_clear     (irq_clear),
   .irq_pending   (irq_pending)
);

// File: tb/smpl_fifo_irq_test.sv
module smpl_fifo_irq_test;

   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_en = 1'b0, dma_en = 1'b0;
   logic [5:0]  dipstick = 6'd4;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [16:0] rd_data;
   logic [5:0]  count;
   logic        empty, almost_empty, full, almost_full;
   logic        starve_err, ovfl_err, dma_req;
   logic [5:0]  irq_mask = '0;
   logic        irq_global_en = 1'b0, irq_clear = 1'b0;
   logic        irq_pending;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   smpl_fifo_irq uut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en),
      .dipstick(dipstick), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .count(count), .empty(empty),
      .almost_empty(almost_empty), .full(full), .almost_full(almost_full),
      .starve_err(starve_err), .ovfl_err(ovfl_err), .dma_req(dma_req),
      .irq_mask(irq_mask), .irq_global_en(irq_global_en),
      .irq_clear(irq_clear), .irq_pending(irq_pending)
   );

   // wr, rd, wdata[16], exp_valid, exp_data[16], exp_count[6]
   localparam logic [40:0] VEC [9] = '{
      {1'b1, 1'b0, 16'hA001, 1'b0, 16'h0000, 6'd1},
      {1'b1, 1'b0, 16'hA002, 1'b0, 16'h0000, 6'd2},
      {1'b1, 1'b1, 16'hA003, 1'b1, 16'hA001, 6'd2},
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'hA002, 6'd1},
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'hA003, 6'd0},
      {1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 6'd0},
      {1'b1, 1'b0, 16'h5555, 1'b0, 16'h0000, 6'd1},
      {1'b1, 1'b1, 16'hFFFF, 1'b1, 16'h5555, 6'd1},
      {1'b0, 1'b1, 16'h0000, 1'b1, 16'hFFFF, 6'd0}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      wr_en = 1'b0; rd_en = 1'b0; irq_clear = 1'b0;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check("R2", "reset count", 32'(count), 0);
      check("R2", "reset empty", 32'(empty), 1);
      check("R1", "reset rd_data", 32'(rd_data), 0);
      check("R10", "reset pending", 32'(irq_pending), 0);
      rst_n = 1'b1;
      fifo_en = 1'b1;
      dma_en = 1'b1;
      step();

      // vector walk
      foreach (VEC[i]) begin
         wr_en = VEC[i][40]; rd_en = VEC[i][39]; wr_data = VEC[i][38:23];
         step();
         check("R1", "vec valid", 32'(rd_data[16]), 32'(VEC[i][22]));
         check("R1", "vec data", 32'(rd_data[15:0]), 32'(VEC[i][21:6]));
         check("R2", "vec count", 32'(count), 32'(VEC[i][5:0]));
      end
      idle();
      step();
      check("R8", "dma idle empty", 32'(dma_req), 0);

      // starvation and interrupt tests
      irq_mask = 6'b010000; irq_global_en = 1'b1;
      rd_en = 1'b1;
      step();
      idle();
      check("R6", "starve set", 32'(starve_err), 1);
      check("R6", "starve no data", 32'(rd_data), 0);
      check("R9", "pending from starve", 32'(irq_pending), 1);
      step();
      check("R6", "starve sticky", 32'(starve_err), 1);
      irq_clear = 1'b1;
      step();
      idle();
      check("R10", "clear starve", 32'(starve_err), 0);
      check("R10", "clear pending", 32'(irq_pending), 0);
      // clear meets a new starvation event
      irq_clear = 1'b1; rd_en = 1'b1;
      step();
      idle();
      check("R10", "clear loses to starve", 32'(starve_err), 1);
      check("R10", "clear loses pending", 32'(irq_pending), 1);
      irq_clear = 1'b1;
      step();
      idle();
      // global gate off
      irq_global_en = 1'b0; rd_en = 1'b1;
      step();
      idle();
      step();
      check("R11", "gated pending", 32'(irq_pending), 0);
      check("R6", "gated starve", 32'(starve_err), 1);
      // masked-out source
      irq_global_en = 1'b1; irq_mask = 6'b000000; irq_clear = 1'b1;
      step();
      idle();
      rd_en = 1'b1;
      step();
      idle();
      check("R9", "masked pending", 32'(irq_pending), 0);
      // level source: empty
      irq_mask = 6'b000001;
      step();
      check("R9", "empty level pending", 32'(irq_pending), 1);
      irq_clear = 1'b1;
      step();
      idle();
      check("R10", "level source wins", 32'(irq_pending), 1);
      irq_mask = 6'b000000; irq_clear = 1'b1;
      step();
      idle();
      check("R10", "cleared", 32'(irq_pending), 0);
      check("R10", "errors cleared", 32'({starve_err, ovfl_err}), 0);

      // fill to full, checking thresholds with watermark 4
      for (int i = 0; i < DEPTH; i++) begin
         wr_en = 1'b1; wr_data = 16'h1000 + 16'(i);
         step();
         if (i == 3) check("R4", "aempty at 4", 32'(almost_empty), 1);
         if (i == 4) check("R4", "aempty at 5", 32'(almost_empty), 0);
         if (i == 26) check("R3", "afull at 27", 32'(almost_full), 0);
         if (i == 27) check("R3", "afull at 28", 32'(almost_full), 1);
         if (i == 30) check("R2", "not full at 31", 32'(full), 0);
      end
      idle();
      check("R2", "full at 32", 32'(full), 1);
      check("R2", "count 32", 32'(count), 32);
      check("R8", "dma with data", 32'(dma_req), 1);
      dma_en = 1'b0;
      #1;
      check("R8", "dma disabled", 32'(dma_req), 0);
      dma_en = 1'b1;
      dipstick = 6'd32;
      #1;
      check("R4", "aempty watermark 32", 32'(almost_empty), 1);
      dipstick = 6'd4;
      // push on full, once alone and once with a pop
      wr_en = 1'b1; wr_data = 16'hDEAD;
      step();
      idle();
      check("R5", "overflow set", 32'(ovfl_err), 1);
      check("R5", "count held", 32'(count), 32);
      wr_en = 1'b1; rd_en = 1'b1; wr_data = 16'hBEEF;
      step();
      idle();
      check("R5", "pop with full push", 32'(rd_data), 32'({1'b1, 16'h1000}));
      check("R5", "count after pop", 32'(count), 31);
      step();
      check("R5", "overflow sticky", 32'(ovfl_err), 1);
      // drain, checking order and that discarded samples are absent
      for (int i = 1; i < DEPTH; i++) begin
         rd_en = 1'b1;
         step();
         check("R1", "drain order", 32'(rd_data), 32'({1'b1, 16'h1000 + 16'(i)}));
      end
      step();
      idle();
      check("R1", "drain past end", 32'(rd_data), 0);
      check("R2", "drained empty", 32'(empty), 1);
      irq_clear = 1'b1;
      step();
      idle();

      // flush by disabling
      for (int i = 0; i < 3; i++) begin
         wr_en = 1'b1; wr_data = 16'h7000 + 16'(i);
         step();
      end
      fifo_en = 1'b0; wr_en = 1'b1; rd_en = 1'b1;
      step();
      check("R7", "flush count", 32'(count), 0);
      check("R7", "disabled no data", 32'(rd_data), 0);
      check("R7", "disabled no error", 32'({starve_err, ovfl_err}), 0);
      check("R8", "dma when disabled", 32'(dma_req), 0);
      idle();
      fifo_en = 1'b1; rd_en = 1'b1;
      step();
      idle();
      check("R7", "empty after flush", 32'(rd_data), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule